// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

When the processor core requests a stop, this controller decides which low-power state the chip enters. It samples five configuration bits in the same cycle as the request: stop enable, debug enable, low-voltage detect enable, low-voltage detect kept on during stop, and power-down select. From these it either raises a one-cycle illegal-opcode reset or moves into one of four stop states. While stopped it drives the internal clock enable and the regulator-active output.

While stopped it watches a vector of asynchronous wake sources. Each source has its own enable bit, and each passes through a two-flop synchronizer. The block returns to run on a reset event (reset pin or low-voltage reset) or on an enabled wake. On exit it pulses one of two outputs that tell the core whether to fetch the reset vector or an interrupt vector. The regulator, the detectors and the core are outside the block and appear only as plain signals.

The request and configuration pins are plain control pins, not a stream. There is no handshake, and a request is never held off: the block acts on it at the next clock edge or ignores it, as the requirements below say.

Top module: `stop_mode_ctrl`

## Requirements
- R1: A `stop_req` sampled in run with `cfg_stop_en`=0 produces a one-cycle `illegal_rst` pulse in the next cycle, and `mode` stays 0 (run).
- R2: With stop enabled and `cfg_dbg_en`=1, the block enters mode 3 (stop3 with debug) whatever the other bits are. `clk_en` stays 1 and `reg_active` stays 1.
- R3: With stop enabled, debug off, and both `cfg_lvd_en` and `cfg_lvd_stop` at 1, the block enters mode 2 (stop3 with regulator active) and holds `reg_active`=1, whatever `cfg_ppd_sel` is.
- R4: With stop enabled, debug off and either low-voltage bit at 0, `cfg_ppd_sel`=0 enters mode 1 (stop3) and `cfg_ppd_sel`=1 enters mode 4 (stop2). In both, `reg_active`=0.
- R5: In modes 1, 2 and 4, `clk_en` is 0 for every cycle the block is stopped. In run, `clk_en` is 1.
- R6: In modes 1, 2 and 3, any wake source whose bit in `wake_mask` is 1 ends the stop. A source whose mask bit is 0 has no effect.
- R7: An exit caused by `pin_reset` pulses `vec_reset` for one cycle. An exit caused by a wake in modes 1 to 3 pulses `vec_irq` for one cycle. The two pulses never occur together.
- R8: `lvd_reset` asserted while stopped ends the stop and is reported as a reset exit through `vec_reset`.
- R9: The configuration bits are captured only with the `stop_req` that enters stop. Changing them, or raising `stop_req` again, while stopped does not change `mode`, `clk_en` or `reg_active`.
- R10: In mode 4 only wake bit 0 (IRQ pin) and wake bit 1 (real-time clock) are accepted. Their exit is reported through `vec_reset`, never `vec_irq`.
- R11: A wake input that rises between two clock edges is still stopped after the first two edges that follow and back in run (mode 0) after the third.
- R12: If a reset event and a wake are both present in the same cycle, the reset wins and the exit is reported through `vec_reset`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| stop_req | input | 1 | Stop request from the core, sampled at the clock edge |
| cfg_stop_en | input | 1 | Stop enable |
| cfg_dbg_en | input | 1 | Debug enable |
| cfg_lvd_en | input | 1 | Low-voltage detect enable |
| cfg_lvd_stop | input | 1 | Low-voltage detect kept on during stop |
| cfg_ppd_sel | input | 1 | Power-down select (0 stop3, 1 stop2) |
| wake_src | input | NUM_WAKE | Asynchronous wake sources; bit 0 is the IRQ pin, bit 1 the real-time clock |
| wake_mask | input | NUM_WAKE | Per-source wake enable |
| pin_reset | input | 1 | Reset pin event |
| lvd_reset | input | 1 | Low-voltage reset event |
| mode | output | 3 | 0 run, 1 stop3, 2 stop3 with regulator active, 3 stop3 with debug, 4 stop2 |
| clk_en | output | 1 | Internal clock enable |
| reg_active | output | 1 | Regulator kept in active state |
| illegal_rst | output | 1 | One-cycle illegal-opcode reset pulse |
| vec_reset | output | 1 | One-cycle pulse: fetch the reset vector |
| vec_irq | output | 1 | One-cycle pulse: fetch an interrupt vector |

## Verification
The stored mode is the only long-lived state, and it drives `mode`, `clk_en` and `reg_active` directly. A wrong decode or a lost capture therefore shows at the ports in the cycle after the request. A corrupted mode that drifts while stopped shows as soon as the configuration pins are toggled during stop. Synchronizer faults, such as a missing or an extra stage, move the run return by one edge, so the exact-edge latency check exposes them. Source-gating faults show only as an exit that should not happen, or as the wrong vector pulse, in the exit cycle.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [2:0] {
    SM_RUN       = 3'd0,
    SM_STOP3     = 3'd1,
    SM_STOP3_REG = 3'd2,
    SM_STOP3_DBG = 3'd3,
    SM_STOP2     = 3'd4
  } smc_mode_e;
endpackage

// File: rtl/smc_mode_sel.sv
module smc_mode_sel
  import smc_pkg::*;
(
  input  logic      stop_en,
  input  logic      dbg_en,
  input  logic      lvd_en,
  input  logic      lvd_stop,
  input  logic      ppd_sel,
  output smc_mode_e next_mode,
  output logic      illegal
);
  // Fixed priority: disabled, debug, low-voltage armed, then power-down select
  always_comb begin
    illegal   = 1'b0;
    next_mode = SM_RUN;
    if (!stop_en)
      illegal = 1'b1;
    else if (dbg_en)
      next_mode = SM_STOP3_DBG;
    else if (lvd_en && lvd_stop)
      next_mode = SM_STOP3_REG;
    else if (ppd_sel)
      next_mode = SM_STOP2;
    else
      next_mode = SM_STOP3;
  end
endmodule

// File: rtl/smc_wake_sync.sv
module smc_wake_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain[LAST];
  end
endmodule

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl
  import smc_pkg::*;
#(
  parameter int NUM_WAKE = 8,
  parameter int IRQ_IDX  = 0,
  parameter int RTC_IDX  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_req,
  input  logic                cfg_stop_en,
  input  logic                cfg_dbg_en,
  input  logic                cfg_lvd_en,
  input  logic                cfg_lvd_stop,
  input  logic                cfg_ppd_sel,
  input  logic [NUM_WAKE-1:0] wake_src,
  input  logic [NUM_WAKE-1:0] wake_mask,
  input  logic                pin_reset,
  input  logic                lvd_reset,
  output logic [2:0]          mode,
  output logic                clk_en,
  output logic                reg_active,
  output logic                illegal_rst,
  output logic                vec_reset,
  output logic                vec_irq
);
  localparam logic [NUM_WAKE-1:0] DEEP_ALLOW =
    (NUM_WAKE'(1) << IRQ_IDX) | (NUM_WAKE'(1) << RTC_IDX);

  smc_mode_e           mode_q;
  smc_mode_e           sel_mode;
  logic                sel_illegal;
  logic [NUM_WAKE-1:0] wake_s;
  logic [NUM_WAKE-1:0] allow;
  logic                stopped;
  logic                rst_event;
  logic                wake_hit;

  smc_mode_sel u_sel (
    .stop_en   (cfg_stop_en),
    .dbg_en    (cfg_dbg_en),
    .lvd_en    (cfg_lvd_en),
    .lvd_stop  (cfg_lvd_stop),
    .ppd_sel   (cfg_ppd_sel),
    .next_mode (sel_mode),
    .illegal   (sel_illegal)
  );

  smc_wake_sync #(.WIDTH(NUM_WAKE), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (wake_src),
    .sync_out (wake_s)
  );

  assign stopped   = (mode_q != SM_RUN);
  assign allow     = (mode_q == SM_STOP2) ? DEEP_ALLOW : '1;
  assign rst_event = pin_reset | lvd_reset;
  assign wake_hit  = |(wake_s & wake_mask & allow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= SM_RUN;
      illegal_rst <= 1'b0;
      vec_reset   <= 1'b0;
      vec_irq     <= 1'b0;
    end else begin
      illegal_rst <= 1'b0;
      vec_reset   <= 1'b0;
      vec_irq     <= 1'b0;
      if (!stopped) begin
        if (stop_req) begin
          if (sel_illegal) illegal_rst <= 1'b1;
          else             mode_q      <= sel_mode;
        end
      end else if (rst_event) begin
        mode_q    <= SM_RUN;
        vec_reset <= 1'b1;
      end else if (wake_hit) begin
        mode_q <= SM_RUN;
        if (mode_q == SM_STOP2) vec_reset <= 1'b1;
        else                    vec_irq   <= 1'b1;
      end
    end
  end

  assign mode       = mode_q;
  assign clk_en     = (mode_q == SM_RUN) || (mode_q == SM_STOP3_DBG);
  assign reg_active = (mode_q != SM_STOP3) && (mode_q != SM_STOP2);

  AST_ILLEGAL_STAYS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && stop_req && !cfg_stop_en) |=> (illegal_rst && mode_q == SM_RUN)); // R1
  AST_CLOCKS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SM_STOP3 || mode_q == SM_STOP3_REG || mode_q == SM_STOP2) |-> !clk_en); // R5
  AST_REG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SM_STOP3_REG) |-> reg_active); // R3
  AST_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && rst_event) |=> (mode_q == SM_RUN && vec_reset && !vec_irq)); // R7
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> (mode_q == SM_RUN || $stable(mode_q))); // R9
  AST_ONE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_reset && vec_irq)); // R7
  AST_DEEP_NO_IRQ_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SM_STOP2) |=> !vec_irq); // R10
endmodule

// File: tb/test_stop_mode_ctrl.sv
module test_stop_mode_ctrl;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stop_req = 1'b0;
  logic          cfg_stop_en = 1'b0, cfg_dbg_en = 1'b0, cfg_lvd_en = 1'b0;
  logic          cfg_lvd_stop = 1'b0, cfg_ppd_sel = 1'b0;
  logic [NW-1:0] wake_src = '0, wake_mask = '1;
  logic          pin_reset = 1'b0, lvd_reset = 1'b0;
  logic [2:0]    mode;
  logic          clk_en, reg_active, illegal_rst, vec_reset, vec_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  stop_mode_ctrl #(.NUM_WAKE(NW)) i_stop_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req),
    .cfg_stop_en(cfg_stop_en), .cfg_dbg_en(cfg_dbg_en), .cfg_lvd_en(cfg_lvd_en),
    .cfg_lvd_stop(cfg_lvd_stop), .cfg_ppd_sel(cfg_ppd_sel),
    .wake_src(wake_src), .wake_mask(wake_mask),
    .pin_reset(pin_reset), .lvd_reset(lvd_reset),
    .mode(mode), .clk_en(clk_en), .reg_active(reg_active),
    .illegal_rst(illegal_rst), .vec_reset(vec_reset), .vec_irq(vec_irq)
  );

  // {stop_en, dbg, lvd_en, lvd_stop, ppd, mode[2:0], clk_en, reg_active, illegal}
  localparam int NV = 10;
  localparam logic [10:0] VEC [NV] = '{
    11'b00000_000_1_1_1,
    11'b01111_000_1_1_1,
    11'b11001_011_1_1_0,
    11'b11110_011_1_1_0,
    11'b10111_010_0_1_0,
    11'b10110_010_0_1_0,
    11'b10100_001_0_0_0,
    11'b10011_100_0_0_0,
    11'b10001_100_0_0_0,
    11'b10000_001_0_0_0
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic request(logic [4:0] cfg);
    {cfg_stop_en, cfg_dbg_en, cfg_lvd_en, cfg_lvd_stop, cfg_ppd_sel} = cfg;
    stop_req = 1'b1;
    tick();
    stop_req = 1'b0;
  endtask

  task automatic reset_exit(string tag);
    pin_reset = 1'b1;
    tick();
    pin_reset = 1'b0;
    check(tag, "mode after reset exit", mode, 0);
    check(tag, "vec_reset on reset exit", vec_reset, 1);
    check(tag, "vec_irq on reset exit", vec_irq, 0);
    tick();
    check(tag, "vec_reset one cycle", vec_reset, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    check("R5", "reset mode", mode, 0);
    check("R5", "reset clk_en", clk_en, 1);
    check("R1", "reset illegal_rst", illegal_rst, 0);
    rst_n = 1'b1;
    tick();

    // Table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      request(VEC[i][10:6]);
      check("R1-R4 table", "mode", mode, int'(VEC[i][5:3]));
      check("R2/R5 table", "clk_en", clk_en, int'(VEC[i][2]));
      check("R3/R4 table", "reg_active", reg_active, int'(VEC[i][1]));
      check("R1 table", "illegal_rst", illegal_rst, int'(VEC[i][0]));
      if (VEC[i][0]) begin
        tick();
        check("R1", "illegal pulse ends", illegal_rst, 0);
      end else begin
        tick();
        check("R5", "still stopped", mode, int'(VEC[i][5:3]));
        reset_exit("R7");
      end
    end

    // R11 + R6 + R7: wake latency in stop3, interrupt vector
    request(5'b10000);
    wake_src[3] = 1'b1;
    tick();
    check("R11", "stopped after 1st edge", mode, 1);
    tick();
    check("R11", "stopped after 2nd edge", mode, 1);
    tick();
    check("R11", "run after 3rd edge", mode, 0);
    check("R7", "vec_irq on wake exit", vec_irq, 1);
    check("R7", "vec_reset on wake exit", vec_reset, 0);
    wake_src = '0;
    tick();
    check("R7", "vec_irq one cycle", vec_irq, 0);
    repeat (3) tick();

    // R6: masked source ignored
    wake_mask = 8'b1111_0111;
    request(5'b10000);
    wake_src[3] = 1'b1;
    repeat (6) tick();
    check("R6", "masked wake ignored", mode, 1);
    check("R6", "no vector on masked wake", vec_irq, 0);
    wake_src[5] = 1'b1;
    repeat (3) tick();
    check("R6", "enabled wake exits", mode, 0);
    check("R6", "vec_irq", vec_irq, 1);
    wake_src = '0;
    wake_mask = '1;
    repeat (4) tick();

    // R10: stop2 ignores other sources, IRQ/RTC exits with reset vector
    request(5'b10001);
    check("R10", "in stop2", mode, 4);
    wake_src[4] = 1'b1;
    repeat (6) tick();
    check("R10", "stop2 ignores bit4", mode, 4);
    wake_src[1] = 1'b1;
    repeat (3) tick();
    check("R10", "rtc exits stop2", mode, 0);
    check("R10", "stop2 exit vec_reset", vec_reset, 1);
    check("R10", "stop2 exit no vec_irq", vec_irq, 0);
    wake_src = '0;
    repeat (4) tick();

    // R10: IRQ pin (bit0) in stop2
    request(5'b10011);
    wake_src[0] = 1'b1;
    repeat (3) tick();
    check("R10", "irq exits stop2", mode, 0);
    check("R10", "irq stop2 vec_reset", vec_reset, 1);
    wake_src = '0;
    repeat (4) tick();

    // R8: low-voltage reset during stop3 with regulator
    request(5'b10110);
    lvd_reset = 1'b1;
    tick();
    lvd_reset = 1'b0;
    check("R8", "lvd reset exits", mode, 0);
    check("R8", "lvd reset vec_reset", vec_reset, 1);
    tick();

    // R6 R7: debug stop3 exits on wake with interrupt vector
    request(5'b11000);
    wake_src[7] = 1'b1;
    repeat (3) tick();
    check("R6", "debug stop wake exit", mode, 0);
    check("R7", "debug stop vec_irq", vec_irq, 1);
    wake_src = '0;
    repeat (4) tick();

    // R9: config changes and repeated request while stopped
    request(5'b10000);
    {cfg_dbg_en, cfg_ppd_sel, cfg_lvd_en, cfg_lvd_stop} = 4'b1111;
    stop_req = 1'b1;
    tick();
    stop_req = 1'b0;
    tick();
    check("R9", "mode unchanged", mode, 1);
    check("R9", "clk_en unchanged", clk_en, 0);
    check("R9", "reg_active unchanged", reg_active, 0);
    cfg_stop_en = 1'b0;
    stop_req = 1'b1;
    tick();
    stop_req = 1'b0;
    check("R9", "no illegal while stopped", illegal_rst, 0);
    check("R9", "still stop3", mode, 1);

    // R12: reset and wake together -> reset vector
    wake_src[2] = 1'b1;
    tick();
    tick();
    pin_reset = 1'b1;
    tick();
    pin_reset = 1'b0;
    check("R12", "run after tie", mode, 0);
    check("R12", "reset wins vec_reset", vec_reset, 1);
    check("R12", "reset wins no vec_irq", vec_irq, 0);
    wake_src = '0;
    repeat (3) tick();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule